// File: doc/BRIEF.md
# Timer Interrupt Route Selector

This block takes the one-cycle fire pulses of a small group of timer channels and turns them into pulses on a vector of interrupt request lines. Each timer supplies its 64-bit configuration word. A 5-bit line number sits in that word, and the upper 32 bits hold a mask of the lines that the timer may drive. A programmed line number is used only if its bit in that mask is set and the number is below the line count. A request that fails this check drives no line and sets a sticky per-timer error flag. Reset is the only way to clear that flag.

A legacy switch overrides routing for the first two timers. With the switch on, timer 0 always drives line 0 and timer 1 always drives line 8, and the mask is not consulted. Timer 2 keeps its programmed line at all times.

Each delivery is an edge. The chosen line is forced low for one cycle and then driven high for one cycle, so even a line that is already high gives a fresh rising edge. While the legacy switch is on and timer 0 is armed, the block also tells the legacy interval timer to mute its channel-0 interrupt.

Top module: `irq_route_sel`

## Requirements
- R1: After reset every bit of `irq_lines` and of `route_err` is 0.
- R2: With `legacy_en` low, a fire of timer t pulses the line whose number is in configuration bits 13:9, provided capability bit (32 + that number) is set. The line is low in the cycle after the clock edge that samples the fire, high in the following cycle, and low again after that.
- R3: Every delivery forces its line low for one cycle before the one-cycle high, even when the line was high at the moment the fire was sampled.
- R4: With `legacy_en` high, a fire of timer 0 pulses line 0 and a fire of timer 1 pulses line 8. The route field and the capability mask are ignored and no error is raised.
- R5: Timer 2 uses its programmed route and capability check whatever the value of `legacy_en`.
- R6: A fire on a programmed route whose capability bit is clear pulses no line and sets `route_err[t]` in the cycle after the sampling edge.
- R7: A route number of 24 or more (at or above the line count) is invalid even if its capability bit is set. It pulses no line and sets `route_err[t]`.
- R8: `route_err` bits are sticky. Later valid fires do not clear them, and only reset does.
- R9: Timers that fire in the same cycle have all of their lines pulsed together. Two timers that route to the same line give one pulse on it.
- R10: `pit_mute` is high exactly when `legacy_en` is high and `tmr_arm[0]` is high, in the same cycle.
- R11: When no timer fires, no line is ever driven high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_en | input | 1 | Legacy routing switch for timers 0 and 1 |
| tmr_arm | input | 3 | Per-timer armed (enabled) flags |
| tmr_fire | input | 3 | Per-timer one-cycle fire pulses |
| tmr_cfg | input | 192 | Configuration words, timer t in bits 64t+63:64t |
| irq_lines | output | 24 | Interrupt request lines |
| route_err | output | 3 | Sticky per-timer invalid-route flags |
| pit_mute | output | 1 | Mute request for the legacy interval timer's channel 0 |

## Verification
The assertions treat `tmr_fire` as a set of independent one-cycle strobes that are sampled on the rising clock edge. They also assume the configuration words and `legacy_en` are stable at the edge where a fire is sampled. The legacy-path property looks only at cases in which no second request for the same line arrives one cycle later. The bench drives every input at the falling edge, holds each fire for exactly one cycle, and changes the configuration only between deliveries. It fires back-to-back on one line only in the case that is meant to test the forced-low cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int CFG_W     = 64;
   localparam int ROUTE_LSB = 9;
   localparam int ROUTE_W   = 5;
   localparam int CAP_LSB   = 32;
   localparam int CAP_W     = 32;
endpackage

// File: rtl/tmr_route_dec.sv
module tmr_route_dec
   import irq_route_pkg::*;
#(
   parameter int TN        = 0,
   parameter int NUM_LINES = 24,
   parameter int LEG_LINE0 = 0,
   parameter int LEG_LINE1 = 8
) (
   input  logic                 legacy_en,
   input  logic                 fire,
   input  logic [CFG_W-1:0]     cfg,
   output logic [NUM_LINES-1:0] line_req,
   output logic                 bad_route
);
   logic [ROUTE_W-1:0]   route;
   logic [CAP_W-1:0]     cap;
   logic                 cap_ok;
   logic [NUM_LINES-1:0] prog_req;

   assign route  = cfg[ROUTE_LSB +: ROUTE_W];
   assign cap    = cfg[CAP_LSB +: CAP_W];
   assign cap_ok = cap[route] && (int'(route) < NUM_LINES);

   always_comb begin
      prog_req = '0;
      if (fire && cap_ok) prog_req[route] = 1'b1;
   end

   generate
      if (TN == 0 || TN == 1) begin : g_legacy
         localparam int LEG = (TN == 0) ? LEG_LINE0 : LEG_LINE1;
         logic [NUM_LINES-1:0] leg_req;
         always_comb begin
            leg_req = '0;
            if (fire) leg_req[LEG] = 1'b1;
         end
         assign line_req  = legacy_en ? leg_req : prog_req;
         assign bad_route = !legacy_en && fire && !cap_ok;
      end else begin : g_prog
         assign line_req  = prog_req;
         assign bad_route = fire && !cap_ok;
      end
   endgenerate

   // a blocked request never reaches any line (R6, R7)
   always_comb begin
      if (bad_route) assert_bad_no_line_R6: assert (line_req == '0);
   end
endmodule

// File: rtl/irq_edge_pulser.sv
module irq_edge_pulser #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req,
   output logic [W-1:0] lines
);
   logic [W-1:0] stg_lo;
   logic [W-1:0] stg_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_lo <= '0;
         stg_hi <= '0;
      end else begin
         stg_lo <= req;
         stg_hi <= stg_lo;
      end
   end

   assign lines = stg_hi & ~stg_lo;

   assert_low_before_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lines & $past(lines)) == '0);
   assert_deassert_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |=> ((lines & $past(req)) == '0));
endmodule

// File: rtl/route_err_flags.sv
module route_err_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   output logic [N-1:0] flags
);
   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= flags | set;
   end

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & $past(flags)) == $past(flags));
endmodule

// File: rtl/irq_route_sel.sv
module irq_route_sel
   import irq_route_pkg::*;
#(
   parameter int NUM_TMR   = 3,
   parameter int NUM_LINES = 24,
   parameter int LEG_LINE0 = 0,
   parameter int LEG_LINE1 = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       legacy_en,
   input  logic [NUM_TMR-1:0]         tmr_arm,
   input  logic [NUM_TMR-1:0]         tmr_fire,
   input  logic [NUM_TMR*CFG_W-1:0]   tmr_cfg,
   output logic [NUM_LINES-1:0]       irq_lines,
   output logic [NUM_TMR-1:0]         route_err,
   output logic                       pit_mute
);
   generate
      if (NUM_TMR < 2)          begin : g_chk_tmr   $error("NUM_TMR must be at least 2");   end
      if (NUM_LINES > CAP_W)    begin : g_chk_lines $error("NUM_LINES exceeds mask width"); end
      if (LEG_LINE0 >= NUM_LINES || LEG_LINE1 >= NUM_LINES)
                                begin : g_chk_leg   $error("legacy line out of range");     end
   endgenerate

   logic [NUM_LINES-1:0] req_tmr [NUM_TMR];
   logic [NUM_TMR-1:0]   bad;
   logic [NUM_LINES-1:0] req_all;

   generate
      for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
         tmr_route_dec #(
            .TN(t), .NUM_LINES(NUM_LINES), .LEG_LINE0(LEG_LINE0), .LEG_LINE1(LEG_LINE1)
         ) u_dec (
            .legacy_en (legacy_en),
            .fire      (tmr_fire[t]),
            .cfg       (tmr_cfg[t*CFG_W +: CFG_W]),
            .line_req  (req_tmr[t]),
            .bad_route (bad[t])
         );

         assert_err_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
            bad[t] |=> route_err[t]);
      end
   endgenerate

   always_comb begin
      req_all = '0;
      for (int t = 0; t < NUM_TMR; t++) req_all = req_all | req_tmr[t];
   end

   irq_edge_pulser #(.W(NUM_LINES)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_all),
      .lines (irq_lines)
   );

   route_err_flags #(.N(NUM_TMR)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (bad),
      .flags (route_err)
   );

   assign pit_mute = legacy_en & tmr_arm[0];

   assert_legacy_t0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && tmr_fire[0]) ##1 !req_all[LEG_LINE0] |=> irq_lines[LEG_LINE0]);
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_all) == '0 && req_all == '0) |=> (irq_lines == '0));
endmodule

// File: tb/irq_route_sel_tb.sv
`timescale 1ns/1ps
module irq_route_sel_tb;
   logic          clk = 1'b0;
   logic          rst_n;
   logic          legacy_en;
   logic [2:0]    tmr_arm;
   logic [2:0]    tmr_fire;
   logic [191:0]  tmr_cfg;
   logic [23:0]   irq_lines;
   logic [2:0]    route_err;
   logic          pit_mute;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   irq_route_sel u_dut (
      .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en), .tmr_arm(tmr_arm),
      .tmr_fire(tmr_fire), .tmr_cfg(tmr_cfg), .irq_lines(irq_lines),
      .route_err(route_err), .pit_mute(pit_mute)
   );

   function automatic logic [63:0] mk_cfg(input logic [31:0] cap, input logic [4:0] route);
      return {cap, 18'b0, route, 9'b0};
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tmr_fire = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic set_cfg(input int t, input logic [31:0] cap, input logic [4:0] route);
      tmr_cfg[t*64 +: 64] = mk_cfg(cap, route);
   endtask

   task automatic pulse_check(input logic [2:0] mask, input logic [23:0] exp, input string tag);
      @(negedge clk); tmr_fire = mask;
      @(negedge clk); tmr_fire = '0;
      check({tag, " low"}, irq_lines & exp, 0);
      @(negedge clk); check({tag, " high"}, irq_lines, exp);
      @(negedge clk); check({tag, " end"}, irq_lines, 0);
   endtask

   task automatic t_reset_R1();
      do_reset();
      check("R1 lines", irq_lines, 0);
      check("R1 err", route_err, 0);
   endtask

   task automatic t_idle_R11();
      bit seen = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (irq_lines != 0) seen = 1;
      end
      check("R11 idle", seen, 0);
   endtask

   task automatic t_route_R2();
      legacy_en = 0;
      set_cfg(2, 32'h0000_0020, 5'd5);
      pulse_check(3'b100, 24'h00_0020, "R2 t2 line5");
      set_cfg(0, 32'h0002_0000, 5'd17);
      pulse_check(3'b001, 24'h02_0000, "R2 t0 line17");
   endtask

   task automatic t_refire_R3();
      set_cfg(2, 32'h0000_0020, 5'd5);
      @(negedge clk); tmr_fire = 3'b100;
      @(negedge clk); tmr_fire = '0;
      @(negedge clk); check("R3 first high", irq_lines[5], 1);
      tmr_fire = 3'b100;
      @(negedge clk); tmr_fire = '0;
      check("R3 forced low", irq_lines[5], 0);
      @(negedge clk); check("R3 second high", irq_lines, 24'h00_0020);
      @(negedge clk); check("R3 one cycle", irq_lines, 0);
   endtask

   task automatic t_legacy_R4();
      legacy_en = 1;
      set_cfg(0, 32'h0, 5'd5);
      set_cfg(1, 32'h0, 5'd3);
      pulse_check(3'b001, 24'h00_0001, "R4 t0 line0");
      pulse_check(3'b010, 24'h00_0100, "R4 t1 line8");
      check("R4 no err", route_err, 0);
   endtask

   task automatic t_t2_R5();
      legacy_en = 1;
      set_cfg(2, 32'h0000_1000, 5'd12);
      pulse_check(3'b100, 24'h00_1000, "R5 t2 line12");
      check("R5 no err", route_err, 0);
   endtask

   task automatic t_multi_R9();
      legacy_en = 0;
      set_cfg(0, 32'h0000_0004, 5'd2);
      set_cfg(1, 32'h0000_0008, 5'd3);
      set_cfg(2, 32'h0000_0008, 5'd3);
      pulse_check(3'b111, 24'h00_000c, "R9 all three");
      legacy_en = 1;
      pulse_check(3'b111, 24'h00_0109, "R9 legacy mix");
      legacy_en = 0;
   endtask

   task automatic t_mute_R10();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         legacy_en = i[1]; tmr_arm = {2'b11, i[0]};
         #1 check("R10 mute", pit_mute, i[1] & i[0]);
      end
      tmr_arm = 3'b111;
      legacy_en = 1;
      #1 check("R10 other arm", pit_mute, 1);
      tmr_arm = 3'b110;
      #1 check("R10 t0 disarmed", pit_mute, 0);
      legacy_en = 0;
   endtask

   task automatic t_cap_R6();
      legacy_en = 0;
      set_cfg(1, 32'hFFFF_FFEF, 5'd4);
      pulse_check(3'b010, 24'h0, "R6 blocked");
      check("R6 err", route_err, 3'b010);
   endtask

   task automatic t_range_R7();
      set_cfg(2, 32'hFFFF_FFFF, 5'd27);
      pulse_check(3'b100, 24'h0, "R7 blocked");
      check("R7 err", route_err, 3'b110);
   endtask

   task automatic t_sticky_R8();
      set_cfg(1, 32'h0000_0010, 5'd4);
      pulse_check(3'b010, 24'h00_0010, "R8 valid after err");
      check("R8 err kept", route_err, 3'b110);
      do_reset();
      check("R8 err cleared by reset", route_err, 0);
   endtask

   initial begin
      legacy_en = 0; tmr_arm = 3'b111; tmr_fire = '0; tmr_cfg = '0; rst_n = 0;
      t_reset_R1();
      t_idle_R11();
      t_route_R2();
      t_refire_R3();
      t_legacy_R4();
      t_t2_R5();
      t_multi_R9();
      t_mute_R10();
      t_cap_R6();
      t_range_R7();
      t_sticky_R8();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog act=hung exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule